// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave with Strobe-Mode Select

This block is the slave side of an 8-bit multiplexed address/data bus. It sits in front of a 128-byte space of registers and RAM. The address comes first on the shared lines and is held in a latch when the address strobe falls. The data phase then carries either a read, with the block driving the lines, or a write, where the block takes the data when the write strobe ends. The storage array lives outside the block and is reached through a plain address, write-data, write-enable and read-data port.

A strapped mode input picks how the two data-phase control pins are read. When it is low, the block uses separate strobes: `ds` is an active-low read strobe and `rw` is an active-low write strobe. When it is high, `ds` is an active-high data strobe and `rw` high means read. The bidirectional lines are split into `ad_in`, `ad_out` and an output enable. No read or write takes place while the supply-good input is low, for a hold-off window after it comes back, or while the device reset pin is low. Address latching carries on in all of these states.

All pins are sampled by the system clock, so strobe edges are found one clock after the pin changes.

Top module: `mbus_slave`

## Requirements
- R1: On the first clock edge at which `as` is seen low after being high, `mem_addr` takes `ad_in[6:0]`. `ad_in[7]` is ignored. Between such edges `mem_addr` holds its value.
- R2: A data phase with `ce_n` high neither drives the bus (`ad_oe` stays 0) nor writes (`mem_we` stays 0). The address is still latched.
- R3: With `mode_moto`=0, holding `ds` low with `ce_n` low sets `ad_oe` at the next clock edge, and `ad_out` then equals the storage byte at the latched address. One edge after `ds` returns high, `ad_oe` is 0.
- R4: With `mode_moto`=0, a low pulse on `rw` with `ce_n` low gives exactly one clock cycle of `mem_we`, at the edge after `rw` rises. `mem_wdata` is the `ad_in` value seen at the last edge of the pulse, and the target is the latched address.
- R5: With `mode_moto`=1, `ds` high with `rw` high and `ce_n` low is a read that behaves as in R3. `ad_oe` clears one edge after `ds` falls.
- R6: With `mode_moto`=1, `ds` high with `rw` low is a write that is committed as a one-cycle `mem_we` on the edge after `ds` falls. Its data is the `ad_in` value seen at the last edge with `ds` high.
- R7: While `pwr_good` is 0, no read or write occurs. After `pwr_good` rises, access opens only once `pwr_good` has been 1 for `HOLD_CYC` edges. A read strobe held from the rise first shows `ad_oe` after edge `HOLD_CYC`+1.
- R8: While `bus_rst_n` is 0, no read or write occurs.
- R9: After `rst_n` reset, `ad_oe`=0, `mem_we`=0 and `mem_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all bus pins |
| rst_n | input | 1 | Active-low logic reset |
| mode_moto | input | 1 | Strobe convention: 0 separate strobes, 1 data strobe plus direction |
| pwr_good | input | 1 | Supply-good indication |
| bus_rst_n | input | 1 | Device reset pin, active low, blocks access |
| ce_n | input | 1 | Chip enable, active low |
| as | input | 1 | Address strobe, address taken on its fall |
| ds | input | 1 | Data/read strobe |
| rw | input | 1 | Write strobe or direction level |
| ad_in | input | 8 | Multiplexed lines, input side |
| ad_out | output | 8 | Multiplexed lines, output side |
| ad_oe | output | 1 | Output enable for the multiplexed lines |
| mem_addr | output | 7 | Latched storage address |
| mem_wdata | output | 8 | Write data to storage |
| mem_we | output | 1 | One-cycle storage write enable |
| mem_rdata | input | 8 | Read data from storage at `mem_addr` |

## Verification
The bench builds the block with `HOLD_CYC`=20. With that value the power-up hold-off boundary can be walked edge by edge, and the last blocked edge and the first open edge can each be checked within a short run. The storage byte count stays at its 128 default, so random addresses with bit 7 set exercise the ignored address bit. Random write/read-back traffic runs in both strobe conventions, and its results are compared against a shadow copy kept in the bench.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int AD_W   = 8;
  localparam int ADDR_W = 7;

  typedef struct packed {
    logic            as;
    logic            ds;
    logic            rw;
    logic            ce_n;
    logic [AD_W-1:0] ad;
  } bus_smp_t;

  // read phase active for the selected strobe convention
  function automatic logic rd_level(input logic moto, input logic ds, input logic rw);
    return moto ? (ds & rw) : ~ds;
  endfunction

  // write phase active for the selected strobe convention
  function automatic logic wr_level(input logic moto, input logic ds, input logic rw);
    return moto ? (ds & ~rw) : ~rw;
  endfunction
endpackage

// File: rtl/mbus_sampler.sv
module mbus_sampler
  import mbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_smp_t cur,
  output bus_smp_t prv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv.as   <= 1'b0;
      prv.ds   <= 1'b1;
      prv.rw   <= 1'b1;
      prv.ce_n <= 1'b1;
      prv.ad   <= '0;
    end else begin
      prv <= cur;
    end
  end
endmodule

// File: rtl/mbus_holdoff.sv
module mbus_holdoff #(
  parameter int HOLD_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ready
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!pwr_good)      cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign ready = pwr_good && (cnt == LIMIT);

  AST_READY_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pwr_good)) else $error("ready rose without supply"); // R7
endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
  import mbus_pkg::*;
(
  input  logic     moto,
  input  bus_smp_t cur,
  input  bus_smp_t prv,
  output logic     rd_act,
  output logic     wr_end,
  output logic     as_fall
);
  logic wr_now, wr_was;

  assign rd_act  = rd_level(moto, cur.ds, cur.rw) & ~cur.ce_n;
  assign wr_now  = wr_level(moto, cur.ds, cur.rw);
  assign wr_was  = wr_level(moto, prv.ds, prv.rw);
  assign wr_end  = wr_was & ~wr_now & ~prv.ce_n;
  assign as_fall = prv.as & ~cur.as;
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
#(
  parameter int HOLD_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_moto,
  input  logic              pwr_good,
  input  logic              bus_rst_n,
  input  logic              ce_n,
  input  logic              as,
  input  logic              ds,
  input  logic              rw,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [AD_W-1:0]   mem_wdata,
  output logic              mem_we,
  input  logic [AD_W-1:0]   mem_rdata
);
  bus_smp_t cur, prv;
  logic     rd_act, wr_end, as_fall, ready, access_ok;

  assign cur = '{as: as, ds: ds, rw: rw, ce_n: ce_n, ad: ad_in};

  mbus_sampler u_smp (.clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv));

  mbus_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ready(ready));

  mbus_strobe u_stb (
    .moto(mode_moto), .cur(cur), .prv(prv),
    .rd_act(rd_act), .wr_end(wr_end), .as_fall(as_fall));

  assign access_ok = ready & bus_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      ad_oe     <= 1'b0;
      ad_out    <= '0;
    end else begin
      if (as_fall) mem_addr <= cur.ad[ADDR_W-1:0];
      mem_we <= wr_end & access_ok;
      if (wr_end & access_ok) mem_wdata <= prv.ad;
      ad_oe  <= rd_act & access_ok;
      ad_out <= mem_rdata;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(mem_addr)) else $error("address moved without strobe"); // R1
  AST_CE_GATES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !ad_oe) else $error("bus driven while deselected"); // R2
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we) else $error("write enable longer than one cycle"); // R4
  AST_PWR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!mem_we && !ad_oe)) else $error("access during supply fail"); // R7
  AST_RST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> (!mem_we && !ad_oe)) else $error("access during device reset"); // R8
endmodule

// File: tb/mbus_slave_test.sv
`timescale 1ns/1ps
module mbus_slave_test;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_moto = 1'b0;
  logic       pwr_good = 1'b1;
  logic       bus_rst_n = 1'b1;
  logic       ce_n = 1'b0;
  logic       as = 1'b0;
  logic       ds = 1'b1;
  logic       rw = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out, mem_wdata, mem_rdata;
  logic       ad_oe, mem_we;
  logic [6:0] mem_addr;

  logic [7:0] mem [128];
  logic [7:0] shadow [128];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbus_slave #(.HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .pwr_good(pwr_good),
    .bus_rst_n(bus_rst_n), .ce_n(ce_n), .as(as), .ds(ds), .rw(rw),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_levels();
    ds = mode_moto ? 1'b0 : 1'b1;
    rw = 1'b1;
  endtask

  task automatic latch_addr(input logic [7:0] a);
    @(negedge clk); as = 1'b1; ad_in = a;
    @(negedge clk); as = 1'b0;
    @(negedge clk); ad_in = 8'($urandom);
  endtask

  // performs a write strobe; returns whether mem_we showed with the data
  task automatic do_write(input logic [7:0] d, output bit we_seen, output logic [7:0] wd);
    @(negedge clk);
    if (mode_moto) begin ds = 1'b1; rw = 1'b0; end else rw = 1'b0;
    ad_in = d;
    @(negedge clk);
    @(negedge clk);
    if (mode_moto) ds = 1'b0; else rw = 1'b1;
    ad_in = 8'($urandom);
    @(negedge clk);
    we_seen = mem_we; wd = mem_wdata;
    idle_levels();
    @(negedge clk);
    if (mem_we) we_seen = 1'b0;
  endtask

  task automatic do_read(output bit oe_seen, output logic [7:0] rd, output bit oe_after);
    @(negedge clk);
    if (mode_moto) begin ds = 1'b1; rw = 1'b1; end else ds = 1'b0;
    @(negedge clk);
    @(negedge clk);
    oe_seen = ad_oe; rd = ad_out;
    idle_levels();
    @(negedge clk);
    oe_after = ad_oe;
  endtask

  task automatic wr_rd_pair(input string wreq, input string rreq);
    logic [7:0] a, d, wd, rd;
    bit we, oe, oe2;
    a = 8'($urandom); d = 8'($urandom);
    latch_addr(a);
    chk(mem_addr == a[6:0], "R1", mem_addr, a[6:0]);
    do_write(d, we, wd);
    chk(we && wd == d, wreq, {we, wd}, {1'b1, d});
    shadow[a[6:0]] = d;
    do_read(oe, rd, oe2);
    chk(oe && rd == shadow[a[6:0]], rreq, {oe, rd}, {1'b1, shadow[a[6:0]]});
    chk(!oe2, rreq, oe2, 0);
  endtask

  initial begin
    logic [7:0] wd, rd;
    bit we, oe, oe2;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 128; i++) begin
      mem[i] = init_byte(i); shadow[i] = init_byte(i);
    end
    repeat (3) @(negedge clk);
    chk(!ad_oe && !mem_we && mem_addr == 0, "R9", {ad_oe, mem_we, mem_addr}, 0);
    rst_n = 1'b1;
    repeat (HOLD + 4) @(negedge clk);

    // R3 / R4: separate-strobe convention, directed then random
    latch_addr(8'hFF);
    chk(mem_addr == 7'h7F, "R1", mem_addr, 7'h7F);
    do_read(oe, rd, oe2);
    chk(oe && rd == shadow[127], "R3", rd, shadow[127]);
    for (int i = 0; i < 25; i++) wr_rd_pair("R4", "R3");

    // R2: deselected write and read
    latch_addr(8'h85);
    chk(mem_addr == 7'h05, "R2", mem_addr, 7'h05);
    ce_n = 1'b1;
    do_write(8'hC3, we, wd);
    chk(!we, "R2", we, 0);
    do_read(oe, rd, oe2);
    chk(!oe, "R2", oe, 0);
    ce_n = 1'b0;
    do_read(oe, rd, oe2);
    chk(oe && rd == shadow[5], "R2", rd, shadow[5]);

    // R8: device reset pin blocks
    bus_rst_n = 1'b0;
    do_write(8'h3C, we, wd);
    chk(!we, "R8", we, 0);
    do_read(oe, rd, oe2);
    chk(!oe, "R8", oe, 0);
    bus_rst_n = 1'b1;
    do_read(oe, rd, oe2);
    chk(oe && rd == shadow[5], "R8", rd, shadow[5]);

    // R5 / R6: data-strobe convention
    @(negedge clk); mode_moto = 1'b1; idle_levels();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 25; i++) wr_rd_pair("R6", "R5");

    // R7: supply fail then hold-off walk with read held
    @(negedge clk); pwr_good = 1'b0;
    do_write(8'h77, we, wd);
    chk(!we, "R7", we, 0);
    @(negedge clk); ds = 1'b1; rw = 1'b1; pwr_good = 1'b1;
    for (int k = 1; k <= HOLD + 2; k++) begin
      @(negedge clk);
      if (k == HOLD || k == 1) chk(!ad_oe, "R7", ad_oe, 0);
      if (k == HOLD + 1) chk(ad_oe == 1'b1, "R7", ad_oe, 1);
    end
    idle_levels();
    repeat (2) @(negedge clk);
    wr_rd_pair("R6", "R5");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule